// File: doc/BRIEF.md
# Master Interrupt Controller with Cascade Lines

This block gathers a set of level-sensitive interrupt request lines and drives one interrupt output toward the processor. Each line holds a mask bit and a cascade bit. A line with its cascade bit clear is a direct source and carries a 7-bit vector. A line with its cascade bit set is fed by a downstream controller. For such a line the block returns a negative table index in place of a vector. That index equals the line number minus the line count, as an 8-bit two's-complement value.

The processor answers the interrupt with an acknowledge strobe. The block returns the code of the winning line and marks that line as in service. When the handler finishes, an end-of-interrupt strobe returns the same code again and retires that line. Retiring the line lets lower-priority requests compete once more. Priority is fixed, with line 0 highest. Service may nest: while a line is in service, only a line of higher priority can raise the output again.

Top module: `intc_master`

## Requirements
- R1: After reset, every line is masked, no line is in service, and int_out, rd_valid and spurious are all 0.
- R2: A line whose mask bit is set never raises int_out, whatever the state of its request.
- R3: When several eligible lines are requesting, an acknowledge serves the lowest-numbered one.
- R4: An acknowledge of a direct line returns {0, stored 7-bit vector}. Bit 7 of the written vector byte is discarded.
- R5: An acknowledge of a cascade line L returns the byte L - NLINES (0xF0 | L for 16 lines), so bit 7 is set.
- R6: rd_valid is high for exactly the one cycle after a cycle with ack or eoi high, and rd_data holds the answer during that cycle.
- R7: While lines are in service, int_out is high only if an unmasked request exists on a line numbered below the lowest in-service line. Such a request can be acknowledged, which nests its service.
- R8: An eoi returns the code of the lowest-numbered in-service line and retires it, so pending requests below it regain int_out.
- R9: An ack while int_out is low returns 0x00 and sets spurious. The next ack that finds int_out high clears spurious.
- R10: An eoi with no line in service returns 0x00 and changes no state.
- R11: If ack and eoi are high in the same cycle, only the acknowledge is performed.
- R12: A configuration write applies cfg_data to line cfg_line, selected by cfg_sel: 0 sets the mask bit from cfg_data[0] (1 = masked); 1 sets the cascade bit from cfg_data[0] (1 = cascade); 2 sets the vector from cfg_data[6:0]; 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | NLINES | Level request per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_line | input | $clog2(NLINES) | Line being configured |
| cfg_data | input | DW | Configuration data |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| int_out | output | 1 | Interrupt request to the processor |
| rd_valid | output | 1 | Answer to ack or eoi is on rd_data |
| rd_data | output | DW | Vector or cascade index |
| spurious | output | 1 | Last acknowledge found nothing to serve |

## Verification
The bench builds the block with its defaults of 16 lines and 8-bit data. At that size the cascade index wraps across the full range from 0xF0 (line 0) to 0xFF (line 15). A direct vector with bit 7 written high shows that the bit is dropped. Nested service runs two levels deep, so the order in which eoi retires lines can be observed. An acknowledge and an eoi arrive together while a line is already in service, which checks that the eoi is dropped.

// File: rtl/intc_master.sv
module intc_master #(
  parameter int NLINES = 16,
  parameter int DW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLINES-1:0]         irq,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [$clog2(NLINES)-1:0] cfg_line,
  input  logic [DW-1:0]             cfg_data,
  input  logic                      ack,
  input  logic                      eoi,
  output logic                      int_out,
  output logic                      rd_valid,
  output logic [DW-1:0]             rd_data,
  output logic                      spurious
);
  localparam int LW = $clog2(NLINES);

  logic [NLINES-1:0] mask_q, casc_q, isr_q;
  logic [DW-2:0]     vec_q [NLINES];
  logic [NLINES-1:0] pend;
  logic              best_v, cur_v;
  logic [LW-1:0]     best_l, cur_l;
  logic [DW-1:0]     ack_code, eoi_code;

  assign pend = irq & ~mask_q & ~isr_q;

  always_comb begin
    best_v = 1'b0;
    best_l = '0;
    cur_v  = 1'b0;
    cur_l  = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        best_v = 1'b1;
        best_l = LW'(i);
      end
      if (isr_q[i]) begin
        cur_v = 1'b1;
        cur_l = LW'(i);
      end
    end
  end

  assign int_out  = best_v && (!cur_v || best_l < cur_l);
  assign ack_code = casc_q[best_l] ? DW'(best_l) - DW'(NLINES) : {1'b0, vec_q[best_l]};
  assign eoi_code = casc_q[cur_l]  ? DW'(cur_l)  - DW'(NLINES) : {1'b0, vec_q[cur_l]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      casc_q   <= '0;
      isr_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      spurious <= 1'b0;
      for (int i = 0; i < NLINES; i++) vec_q[i] <= '0;
    end else begin
      rd_valid <= ack | eoi;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0:    mask_q[cfg_line] <= cfg_data[0];
          2'd1:    casc_q[cfg_line] <= cfg_data[0];
          2'd2:    vec_q[cfg_line]  <= cfg_data[DW-2:0];
          default: ;
        endcase
      end
      if (ack) begin
        if (int_out) begin
          isr_q[best_l] <= 1'b1;
          rd_data       <= ack_code;
          spurious      <= 1'b0;
        end else begin
          rd_data  <= '0;
          spurious <= 1'b1;
        end
      end else if (eoi) begin
        if (cur_v) begin
          isr_q[cur_l] <= 1'b0;
          rd_data      <= eoi_code;
        end else begin
          rd_data <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/intc_master_chk.sv
module intc_master_chk #(
  parameter int NLINES = 16,
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] irq,
  input logic              ack,
  input logic              eoi,
  input logic              int_out,
  input logic              rd_valid,
  input logic [DW-1:0]     rd_data,
  input logic              spurious,
  input logic [NLINES-1:0] isr_q
);
  p_answer_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || eoi) |=> rd_valid);
  p_answer_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack || eoi) |=> !rd_valid);
  p_spurious_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out) |=> (rd_data == '0 && spurious));
  p_cascade_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_data[DW-1]) |-> ((~rd_data) < DW'(NLINES)));
  p_enter_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out) |=> (isr_q != '0));
  p_needs_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irq != '0));
endmodule

bind intc_master intc_master_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .ack(ack), .eoi(eoi),
  .int_out(int_out), .rd_valid(rd_valid), .rd_data(rd_data),
  .spurious(spurious), .isr_q(isr_q)
);

// File: tb/intc_master_tb.sv
module intc_master_tb;
  localparam int CLK_P = 10;
  localparam int N = 16;

  logic         clk = 0, rst_n = 0;
  logic [N-1:0] irq = '0;
  logic         cfg_we = 0;
  logic [1:0]   cfg_sel = '0;
  logic [3:0]   cfg_line = '0;
  logic [7:0]   cfg_data = '0;
  logic         ack = 0, eoi = 0;
  logic         int_out, rd_valid, spurious;
  logic [7:0]   rd_data;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  intc_master #(.NLINES(N), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_line(cfg_line), .cfg_data(cfg_data), .ack(ack), .eoi(eoi),
    .int_out(int_out), .rd_valid(rd_valid), .rd_data(rd_data), .spurious(spurious)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int line, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_line = 4'(line); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic strobe(input logic a, input logic e, input logic [7:0] exp, input string req);
    @(negedge clk);
    ack = a; eoi = e;
    @(negedge clk);
    ack = 0; eoi = 0;
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk(req, int'(rd_data), int'(exp));
    @(negedge clk);
    chk("R6 rd_valid drops", int'(rd_valid), 0);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 int_out", int'(int_out), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 spurious", int'(spurious), 0);
    irq = '1; settle();
    chk("R1 all masked", int'(int_out), 0);
    irq = '0;
  endtask

  task automatic t_mask();
    wr(2'd0, 5, 8'h00);
    irq[5] = 1; settle();
    chk("R12 unmask raises int_out", int'(int_out), 1);
    wr(2'd0, 5, 8'h01); settle();
    chk("R2 masked line silent", int'(int_out), 0);
    wr(2'd0, 5, 8'h00);
    wr(2'd3, 5, 8'h01); settle();
    chk("R12 sel 3 leaves mask", int'(int_out), 1);
    irq[5] = 0;
  endtask

  task automatic t_direct();
    wr(2'd2, 5, 8'hA3);
    irq[5] = 1;
    strobe(1, 0, 8'h23, "R4 direct vector bit7 dropped");
    chk("R7 in-service blocks same line", int'(int_out), 0);
    strobe(0, 1, 8'h23, "R8 eoi repeats vector");
    settle();
    chk("R8 re-prioritized", int'(int_out), 1);
    irq[5] = 0;
  endtask

  task automatic t_priority();
    wr(2'd0, 2, 8'h00); wr(2'd0, 9, 8'h00);
    wr(2'd2, 2, 8'h12); wr(2'd2, 9, 8'h19);
    irq[2] = 1; irq[9] = 1;
    strobe(1, 0, 8'h12, "R3 lowest line wins");
    chk("R7 lower priority held off", int'(int_out), 0);
    strobe(0, 1, 8'h12, "R8 eoi line 2");
    irq[2] = 0; settle();
    chk("R8 line 9 regains int_out", int'(int_out), 1);
    strobe(1, 0, 8'h19, "R3 next line");
    strobe(0, 1, 8'h19, "R8 eoi line 9");
    irq[9] = 0;
  endtask

  task automatic t_cascade();
    wr(2'd1, 3, 8'h01); wr(2'd0, 3, 8'h00);
    wr(2'd1, 15, 8'h01); wr(2'd0, 15, 8'h00);
    wr(2'd1, 0, 8'h01); wr(2'd0, 0, 8'h00);
    irq[3] = 1;
    strobe(1, 0, 8'hF3, "R5 cascade index line 3");
    strobe(0, 1, 8'hF3, "R8 eoi repeats index");
    irq[3] = 0; irq[15] = 1;
    strobe(1, 0, 8'hFF, "R5 cascade index line 15");
    strobe(0, 1, 8'hFF, "R8 eoi line 15");
    irq[15] = 0; irq[0] = 1;
    strobe(1, 0, 8'hF0, "R5 cascade index line 0");
    strobe(0, 1, 8'hF0, "R8 eoi line 0");
    irq[0] = 0;
  endtask

  task automatic t_nested();
    irq[9] = 1;
    strobe(1, 0, 8'h19, "R7 outer ack");
    irq[2] = 1; settle();
    chk("R7 higher line interrupts", int'(int_out), 1);
    strobe(1, 0, 8'h12, "R7 nested ack");
    strobe(0, 1, 8'h12, "R8 eoi retires inner first");
    strobe(0, 1, 8'h19, "R8 eoi retires outer");
    irq[2] = 0; irq[9] = 0;
  endtask

  task automatic t_spurious();
    settle();
    strobe(1, 0, 8'h00, "R9 empty ack returns 0");
    chk("R9 spurious set", int'(spurious), 1);
    irq[5] = 1;
    strobe(1, 0, 8'h23, "R9 valid ack");
    chk("R9 spurious cleared", int'(spurious), 0);
    strobe(0, 1, 8'h23, "R8 eoi line 5");
    irq[5] = 0;
  endtask

  task automatic t_eoi_empty();
    strobe(0, 1, 8'h00, "R10 empty eoi returns 0");
    irq[9] = 1; settle();
    chk("R10 no state change", int'(int_out), 1);
    chk("R10 spurious untouched", int'(spurious), 0);
    irq[9] = 0;
  endtask

  task automatic t_both();
    irq[9] = 1;
    strobe(1, 0, 8'h19, "R11 setup ack");
    irq[5] = 1;
    strobe(1, 1, 8'h23, "R11 ack wins");
    strobe(0, 1, 8'h23, "R11 eoi line 5");
    strobe(0, 1, 8'h19, "R11 line 9 still in service");
    irq = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_mask();
    t_direct();
    t_priority();
    t_cascade();
    t_nested();
    t_spurious();
    t_eoi_empty();
    t_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule